// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block sits in front of a ring of counter groups, each holding three 16-bit counter channels. It picks, for every channel, the signal that advances the counter and the signal that enables it. Each channel has a clock-select code and a gate-select code, both 5 bits wide, loaded through a write-only register port. The clock choices are: the channel's own connector pin, a shared external clock per group, internal rates of 20 MHz down to 1 kHz, constant levels, the pattern-present flag, and the output of a neighbouring channel. The gate choices are constant levels, the gate pin in either polarity, another neighbour's output in either polarity, and three pattern signals, each in either polarity.

The 20 MHz system clock drives a decade divider chain that produces the internal rates as one-cycle enable strobes. Clock sources that are levels go through a rising-edge detector. As a result, the `ctr_clk_en` output is always a count-enable strobe in the system clock domain. Neighbour routing follows a ring across groups, so the last group feeds the first. The router also sets the direction of each channel's clock and gate connector pins and drives the value a pin carries when it is an output.

Top module: `ctr_src_router`

## Requirements
- R1: Synchronous reset loads clock code 0 and gate code 0 into every channel. As a result, all clock pins become inputs, all gate pins become outputs, and every gate is high.
- R2: When `wr_en` is high, `wr_addr` bit 0 selects the register: 0 is the clock select, 1 is the gate select. `wr_addr[ADDR_W-1:1]` is the channel number (group*3 + channel), and the new code is `wr_data`. A write to a channel number at or above the channel count changes nothing.
- R3: Clock codes 0 (own clock pin), 6 (neighbour output), 7 (the group's external clock), 8 (high), 9 (low) and 10 (pattern present) are levels. `ctr_clk_en` is high in a cycle exactly when the selected level is 1 and the value registered at the previous edge was 0.
- R4: Clock codes 11, 1, 2, 3, 4 and 5 give strobes with periods of 1, 2, 20, 200, 2000 and 20000 cycles. With n clock edges since reset, they fire when n mod period equals period-1; code 11 fires every cycle.
- R5: Clock code 6 on channel c>0 takes the output of channel c-1 in the same group. On channel 0 it takes channel 2 of the preceding group, and group 0 is preceded by the last group.
- R6: Gate code 0 is high and code 1 is low. Code 2 is the gate pin and code 6 its inverse. Code 7 is the output of the "n-2" neighbour and code 3 its inverse. For channel 2 that neighbour is channel 0 of the same group; for channel c<2 it is channel c+1 of the preceding group, using the same ring.
- R7: Gate codes 8, 9 and 10 pass the pattern-present, pattern-occurred and still-present signals. Codes 11, 12 and 13 pass their inverses.
- R8: Each channel has its own pattern latches. The occurred latch is set at the first edge that sees pattern present high. The still-present latch starts high and falls at an edge that sees pattern present low after the occurred latch is set. A write to that channel's gate select sets occurred to 0 and still-present to 1.
- R9: Every code without a meaning (clock 12 to 31; gate 4, 5 and 14 to 31) routes a constant low, which gives no clock strobe and a low gate.
- R10: `clk_pin_oe` is 0 exactly when the clock code is 0. `gat_pin_oe` is 0 exactly when the gate code is 2.
- R11: `clk_pin_out` carries the selected clock signal (the level, or the strobe for codes 1 to 5 and 11). `gat_pin_out` carries the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | ADDR_W | channel number and register bit |
| wr_data | input | 5 | select code to store |
| clk_pin_in | input | NUM_CH | per-channel clock connector pin |
| gat_pin_in | input | NUM_CH | per-channel gate connector pin |
| ext_clk_in | input | NUM_GRP | shared external clock per group |
| ctr_out_in | input | NUM_CH | counter channel outputs |
| pattern_in | input | 1 | pattern-present flag |
| ctr_clk_en | output | NUM_CH | count-enable strobe per channel |
| ctr_gate | output | NUM_CH | gate level per channel |
| clk_pin_oe | output | NUM_CH | clock pin drive enable |
| clk_pin_out | output | NUM_CH | value driven on clock pin |
| gat_pin_oe | output | NUM_CH | gate pin drive enable |
| gat_pin_out | output | NUM_CH | value driven on gate pin |

## Verification
The assertions assume that every pin, counter output and pattern input is already synchronous to `clk` and changes only between edges. The edge detector and the pattern latches then see exactly one value per cycle. The bench follows this by driving every input on the falling edge. It mixes random levels with a pattern input that toggles rarely, so that both latches pass through all their states. Random writes cover valid and out-of-range channel numbers, and the codes are biased toward the assigned ones but also reach the unassigned ones.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;
    localparam int CH_PER_GRP  = 3;
    localparam int SEL_W       = 5;
    localparam int NUM_DECADES = 4;
    localparam int NUM_TICKS   = NUM_DECADES + 2;

    typedef logic [SEL_W-1:0] sel_t;

    localparam sel_t CK_PIN  = 5'd0;
    localparam sel_t CK_NBR  = 5'd6;
    localparam sel_t CK_EXT  = 5'd7;
    localparam sel_t CK_HIGH = 5'd8;
    localparam sel_t CK_LOW  = 5'd9;
    localparam sel_t CK_PAT  = 5'd10;
    localparam sel_t CK_FULL = 5'd11;

    localparam sel_t GT_ON    = 5'd0;
    localparam sel_t GT_OFF   = 5'd1;
    localparam sel_t GT_PIN   = 5'd2;
    localparam sel_t GT_NNBR  = 5'd3;
    localparam sel_t GT_NPIN  = 5'd6;
    localparam sel_t GT_NBR   = 5'd7;
    localparam sel_t GT_PAT   = 5'd8;
    localparam sel_t GT_OCC   = 5'd9;
    localparam sel_t GT_STILL = 5'd10;
    localparam sel_t GT_NPAT  = 5'd11;
    localparam sel_t GT_NOCC  = 5'd12;
    localparam sel_t GT_NSTIL = 5'd13;

    typedef struct packed {
        logic occurred;
        logic still;
    } pat_latch_t;

    function automatic logic is_tick_code(sel_t c);
        return (c >= 5'd1 && c <= 5'd5) || (c == CK_FULL);
    endfunction

    function automatic int prev_grp(int g, int ngrp);
        return (g + ngrp - 1) % ngrp;
    endfunction

    function automatic int clk_nbr_idx(int g, int c, int ngrp);
        return (c > 0) ? g * CH_PER_GRP + c - 1
                       : prev_grp(g, ngrp) * CH_PER_GRP + 2;
    endfunction

    function automatic int gate_nbr_idx(int g, int c, int ngrp);
        return (c == 2) ? g * CH_PER_GRP
                        : prev_grp(g, ngrp) * CH_PER_GRP + c + 1;
    endfunction
endpackage

// File: rtl/ctr_tick_gen.sv
module ctr_tick_gen
    import ctr_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    output logic [NUM_TICKS-1:0] ticks_o
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= ~half_q;
    end

    assign ticks_o[0] = 1'b1;
    assign ticks_o[1] = half_q;

    p_half_alt_r4: assert property (@(posedge clk) disable iff (rst)
        ticks_o[1] |=> !ticks_o[1]);

    for (genvar i = 0; i < NUM_DECADES; i++) begin : g_dec
        logic [3:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst)                 cnt_q <= '0;
            else if (ticks_o[i + 1]) cnt_q <= (cnt_q == 4'd9) ? 4'd0 : cnt_q + 4'd1;
        end
        assign ticks_o[i + 2] = ticks_o[i + 1] & (cnt_q == 4'd9);

        p_dec_sparse_r4: assert property (@(posedge clk) disable iff (rst)
            ticks_o[i + 2] |=> !ticks_o[i + 2]);
    end
endmodule

// File: rtl/ctr_chan_route.sv
module ctr_chan_route
    import ctr_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_clk_sel,
    input  logic                 wr_gate_sel,
    input  sel_t                 wr_data,
    input  logic [NUM_TICKS-1:0] ticks,
    input  logic                 clk_pin_i,
    input  logic                 gat_pin_i,
    input  logic                 ext_clk_i,
    input  logic                 nbr_clk_i,
    input  logic                 nbr_gate_i,
    input  logic                 pattern_i,
    output logic                 cnt_en_o,
    output logic                 gate_o,
    output logic                 clk_oe_o,
    output logic                 gat_oe_o,
    output logic                 clk_pin_o,
    output logic                 gat_pin_o
);
    sel_t       clk_sel_q, gate_sel_q;
    pat_latch_t pat_q;
    logic       lvl_prev_q;
    logic       clk_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sel_q  <= CK_PIN;
            gate_sel_q <= GT_ON;
            pat_q      <= '{occurred: 1'b0, still: 1'b1};
            lvl_prev_q <= 1'b0;
        end else begin
            lvl_prev_q <= clk_lvl;
            if (wr_clk_sel) clk_sel_q <= wr_data;
            if (wr_gate_sel) begin
                gate_sel_q <= wr_data;
                pat_q      <= '{occurred: 1'b0, still: 1'b1};
            end else begin
                pat_q.occurred <= pat_q.occurred | pattern_i;
                pat_q.still    <= pat_q.still & ~(pat_q.occurred & ~pattern_i);
            end
        end
    end

    always_comb begin
        case (clk_sel_q)
            CK_PIN:                 clk_lvl = clk_pin_i;
            5'd1, 5'd2, 5'd3,
            5'd4, 5'd5:             clk_lvl = ticks[clk_sel_q[2:0]];
            CK_NBR:                 clk_lvl = nbr_clk_i;
            CK_EXT:                 clk_lvl = ext_clk_i;
            CK_HIGH:                clk_lvl = 1'b1;
            CK_PAT:                 clk_lvl = pattern_i;
            CK_FULL:                clk_lvl = ticks[0];
            default:                clk_lvl = 1'b0;
        endcase
    end

    always_comb begin
        case (gate_sel_q)
            GT_ON:    gate_o = 1'b1;
            GT_PIN:   gate_o = gat_pin_i;
            GT_NNBR:  gate_o = ~nbr_gate_i;
            GT_NPIN:  gate_o = ~gat_pin_i;
            GT_NBR:   gate_o = nbr_gate_i;
            GT_PAT:   gate_o = pattern_i;
            GT_OCC:   gate_o = pat_q.occurred;
            GT_STILL: gate_o = pat_q.still;
            GT_NPAT:  gate_o = ~pattern_i;
            GT_NOCC:  gate_o = ~pat_q.occurred;
            GT_NSTIL: gate_o = ~pat_q.still;
            default:  gate_o = 1'b0;
        endcase
    end

    assign cnt_en_o  = is_tick_code(clk_sel_q) ? clk_lvl : (clk_lvl & ~lvl_prev_q);
    assign clk_oe_o  = (clk_sel_q != CK_PIN);
    assign gat_oe_o  = (gate_sel_q != GT_PIN);
    assign clk_pin_o = clk_lvl;
    assign gat_pin_o = gate_o;

    p_rst_state_r1: assert property (@(posedge clk)
        rst |=> (!clk_oe_o && gat_oe_o && gate_o));
    p_clk_in_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_clk_sel && wr_data == CK_PIN) |=> !clk_oe_o);
    p_clk_out_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_clk_sel && wr_data != CK_PIN) |=> clk_oe_o);
    p_gate_in_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_gate_sel && wr_data == GT_PIN) |=> !gat_oe_o);
    p_occ_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pat_q.occurred && !wr_gate_sel) |=> pat_q.occurred);
    p_still_order_r8: assert property (@(posedge clk) disable iff (rst)
        !pat_q.still |-> pat_q.occurred);
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        wr_gate_sel |=> (!pat_q.occurred && pat_q.still));
    p_const_low_r9: assert property (@(posedge clk) disable iff (rst)
        (clk_sel_q == CK_LOW) |-> !cnt_en_o);
endmodule

// File: rtl/ctr_src_router.sv
module ctr_src_router
    import ctr_route_pkg::*;
#(
    parameter  int NUM_GRP = 2,
    localparam int NUM_CH  = NUM_GRP * CH_PER_GRP,
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SEL_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] clk_pin_in,
    input  logic [NUM_CH-1:0] gat_pin_in,
    input  logic [NUM_GRP-1:0] ext_clk_in,
    input  logic [NUM_CH-1:0] ctr_out_in,
    input  logic              pattern_in,
    output logic [NUM_CH-1:0] ctr_clk_en,
    output logic [NUM_CH-1:0] ctr_gate,
    output logic [NUM_CH-1:0] clk_pin_oe,
    output logic [NUM_CH-1:0] clk_pin_out,
    output logic [NUM_CH-1:0] gat_pin_oe,
    output logic [NUM_CH-1:0] gat_pin_out
);
    logic [NUM_TICKS-1:0] ticks;
    logic [IDX_W-1:0]     wr_idx;

    assign wr_idx = wr_addr[ADDR_W-1:1];

    ctr_tick_gen u_ticks (
        .clk     (clk),
        .rst     (rst),
        .ticks_o (ticks)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        for (genvar c = 0; c < CH_PER_GRP; c++) begin : g_ch
            localparam int K  = g * CH_PER_GRP + c;
            localparam int NC = clk_nbr_idx(g, c, NUM_GRP);
            localparam int NG = gate_nbr_idx(g, c, NUM_GRP);
            logic hit;
            assign hit = wr_en && (wr_idx == IDX_W'(K));

            ctr_chan_route u_ch (
                .clk         (clk),
                .rst         (rst),
                .wr_clk_sel  (hit && !wr_addr[0]),
                .wr_gate_sel (hit && wr_addr[0]),
                .wr_data     (wr_data),
                .ticks       (ticks),
                .clk_pin_i   (clk_pin_in[K]),
                .gat_pin_i   (gat_pin_in[K]),
                .ext_clk_i   (ext_clk_in[g]),
                .nbr_clk_i   (ctr_out_in[NC]),
                .nbr_gate_i  (ctr_out_in[NG]),
                .pattern_i   (pattern_in),
                .cnt_en_o    (ctr_clk_en[K]),
                .gate_o      (ctr_gate[K]),
                .clk_oe_o    (clk_pin_oe[K]),
                .gat_oe_o    (gat_pin_oe[K]),
                .clk_pin_o   (clk_pin_out[K]),
                .gat_pin_o   (gat_pin_out[K])
            );
        end
    end
endmodule

// File: tb/tb_ctr_src_router.sv
module tb_ctr_src_router;
    localparam int G   = 2;
    localparam int NCH = 6;
    localparam int AW  = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst, wr_en, pattern_in;
    logic [AW-1:0]  wr_addr;
    logic [4:0]     wr_data;
    logic [NCH-1:0] clk_pin_in, gat_pin_in, ctr_out_in;
    logic [G-1:0]   ext_clk_in;
    logic [NCH-1:0] ctr_clk_en, ctr_gate, clk_pin_oe, clk_pin_out, gat_pin_oe, gat_pin_out;

    ctr_src_router #(.NUM_GRP(G)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clk_pin_in(clk_pin_in), .gat_pin_in(gat_pin_in), .ext_clk_in(ext_clk_in),
        .ctr_out_in(ctr_out_in), .pattern_in(pattern_in),
        .ctr_clk_en(ctr_clk_en), .ctr_gate(ctr_gate), .clk_pin_oe(clk_pin_oe),
        .clk_pin_out(clk_pin_out), .gat_pin_oe(gat_pin_oe), .gat_pin_out(gat_pin_out)
    );

    int checks = 0, errors = 0, n = 0;
    logic [4:0] m_csel [NCH];
    logic [4:0] m_gsel [NCH];
    logic       m_occ [NCH], m_still [NCH], m_prev [NCH];

    function automatic logic tick_of(int code, int nn);
        case (code)
            11: return 1'b1;
            1:  return (nn % 2) == 1;
            2:  return (nn % 20) == 19;
            3:  return (nn % 200) == 199;
            4:  return (nn % 2000) == 1999;
            5:  return (nn % 20000) == 19999;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int ring_prev(int g);
        return (g == 0) ? G - 1 : g - 1;
    endfunction

    function automatic int nbr1(int k);
        return (k % 3 > 0) ? k - 1 : ring_prev(k / 3) * 3 + 2;
    endfunction

    function automatic int nbr2(int k);
        return (k % 3 == 2) ? k - 2 : ring_prev(k / 3) * 3 + (k % 3) + 1;
    endfunction

    function automatic logic exp_lvl(int k);
        int c = int'(m_csel[k]);
        if (c >= 1 && c <= 5 || c == 11) return tick_of(c, n);
        case (c)
            0:  return clk_pin_in[k];
            6:  return ctr_out_in[nbr1(k)];
            7:  return ext_clk_in[k / 3];
            8:  return 1'b1;
            10: return pattern_in;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_en(int k);
        int c = int'(m_csel[k]);
        if (c >= 1 && c <= 5 || c == 11) return exp_lvl(k);
        return exp_lvl(k) & ~m_prev[k];
    endfunction

    function automatic logic exp_gate(int k);
        case (int'(m_gsel[k]))
            0:  return 1'b1;
            2:  return gat_pin_in[k];
            3:  return ~ctr_out_in[nbr2(k)];
            6:  return ~gat_pin_in[k];
            7:  return ctr_out_in[nbr2(k)];
            8:  return pattern_in;
            9:  return m_occ[k];
            10: return m_still[k];
            11: return ~pattern_in;
            12: return ~m_occ[k];
            13: return ~m_still[k];
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string tag, logic [NCH-1:0] got, logic [NCH-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b (n=%0d)", tag, got, exp, n);
        end
    endtask

    task automatic check_all();
        logic [NCH-1:0] e_en, e_g, e_co, e_go, e_cp;
        for (int k = 0; k < NCH; k++) begin
            e_en[k] = exp_en(k);
            e_g[k]  = exp_gate(k);
            e_co[k] = (m_csel[k] != 5'd0);
            e_go[k] = (m_gsel[k] != 5'd2);
            e_cp[k] = exp_lvl(k);
        end
        chk("R3 R4 R5 R9 clk_en", ctr_clk_en, e_en);
        chk("R6 R7 R8 R9 gate", ctr_gate, e_g);
        chk("R10 clk_oe", clk_pin_oe, e_co);
        chk("R10 gat_oe", gat_pin_oe, e_go);
        chk("R11 clk_out", clk_pin_out, e_cp);
        chk("R11 gat_out", gat_pin_out, e_g);
    endtask

    task automatic model_edge();
        logic lv [NCH];
        int   idx = int'(wr_addr[AW-1:1]);
        for (int k = 0; k < NCH; k++) lv[k] = exp_lvl(k);
        if (rst) begin
            n = 0;
            for (int k = 0; k < NCH; k++) begin
                m_csel[k] = 5'd0; m_gsel[k] = 5'd0;
                m_occ[k] = 1'b0; m_still[k] = 1'b1; m_prev[k] = 1'b0;
            end
            return;
        end
        for (int k = 0; k < NCH; k++) begin
            m_prev[k] = lv[k];
            if (wr_en && idx == k && wr_addr[0]) begin
                m_gsel[k] = wr_data; m_occ[k] = 1'b0; m_still[k] = 1'b1;
            end else begin
                m_still[k] = m_still[k] & ~(m_occ[k] & ~pattern_in);
                m_occ[k]   = m_occ[k] | pattern_in;
            end
            if (wr_en && idx == k && !wr_addr[0]) m_csel[k] = wr_data;
        end
        n++;
    endtask

    task automatic step(bit do_chk);
        #1;
        if (do_chk) check_all();
        @(posedge clk);
        #0 model_edge();
        @(negedge clk);
    endtask

    task automatic wr(int ch, bit gate, int code);
        wr_en = 1'b1; wr_addr = {3'(ch), gate}; wr_data = 5'(code);
        step(1'b1);
        wr_en = 1'b0;
    endtask

    initial begin
        #(150000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int en_cnt;
        void'($urandom(32'd4242));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; pattern_in = 1'b0;
        clk_pin_in = '0; gat_pin_in = '0; ctr_out_in = '0; ext_clk_in = '0;
        @(negedge clk);
        step(1'b0); step(1'b0);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 clk_oe after reset", clk_pin_oe, '0);
        chk("R1 gat_oe after reset", gat_pin_oe, '1);
        chk("R1 gate after reset", ctr_gate, '1);
        step(1'b1);

        // R2 addressing and ignored out-of-range channel
        wr(4, 1'b1, 1);
        #1 chk("R2 gate write ch4", ctr_gate, 6'b101111);
        wr(7, 1'b1, 1);
        wr(6, 1'b0, 8);
        #1 chk("R2 out-of-range write ignored", ctr_gate, 6'b101111);
        chk("R2 out-of-range clk ignored", clk_pin_oe, 6'b000000);

        // R5 ring for clock code 6
        wr(0, 1'b0, 6); wr(3, 1'b0, 6);
        ctr_out_in = '0; step(1'b1);
        ctr_out_in = 6'b100100;
        #1 chk("R5 ch0<-ch5 ch3<-ch2 edge", ctr_clk_en & 6'b001001, 6'b001001);
        step(1'b1);
        #1 chk("R3 no strobe while level held", ctr_clk_en & 6'b001001, 6'b000000);

        // R6 gate neighbour n-2
        wr(1, 1'b1, 7); wr(2, 1'b1, 3); wr(4, 1'b1, 7);
        ctr_out_in = 6'b100000;
        #1 chk("R6 ch1<-ch5 ch4<-ch2 ch2<-~ch0", ctr_gate & 6'b010110, 6'b000110);

        // R8 pattern latches
        wr(0, 1'b1, 9); wr(3, 1'b1, 10);
        pattern_in = 1'b1; step(1'b1);
        #1 chk("R8 occurred set", {ctr_gate[3], ctr_gate[0]}, 2'b11);
        pattern_in = 1'b0; step(1'b1);
        #1 chk("R8 still falls", {ctr_gate[3], ctr_gate[0]}, 2'b01);
        wr(3, 1'b1, 10); wr(0, 1'b1, 9);
        #1 chk("R8 cleared by rewrite", {ctr_gate[3], ctr_gate[0]}, 2'b10);

        // R4 internal rates, full 1 kHz period
        for (int k = 0; k < NCH; k++) wr(k, 1'b0, (k == 5) ? 11 : k + 1);
        en_cnt = 0;
        for (int i = 0; i < 20100; i++) begin
            #1 if (ctr_clk_en[4]) en_cnt++;
            step(1'b1);
        end
        checks++;
        if (en_cnt != 1) begin
            errors++;
            $display("FAIL R4 1kHz strobe count got %0d exp 1", en_cnt);
        end

        // random phase
        for (int i = 0; i < 4000; i++) begin
            clk_pin_in = NCH'($urandom); gat_pin_in = NCH'($urandom);
            ctr_out_in = NCH'($urandom); ext_clk_in = G'($urandom);
            if ($urandom % 8 == 0) pattern_in = ~pattern_in;
            wr_en = ($urandom % 4 == 0);
            wr_addr = AW'($urandom);
            wr_data = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 14);
            step(1'b1);
        end
        wr_en = 1'b0;
        step(1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule